// File: doc/BRIEF.md
# Programmable-Length RAM Delay Line

This block delays a data stream by a number of clock cycles chosen at run time. The delay can be changed while the line is running. The samples are held in a single-port synchronous RAM that is used as a circular buffer. The RAM returns the old contents of a location in the same cycle that it stores the new sample there.

The RAM address comes from a down-counter. It starts at the requested delay minus two and counts down by one every clock. When the next value would go below zero, which the sign bit of the decremented value shows, the counter reloads instead. The length seen by one pass is therefore fixed when that pass starts. A new length takes effect at the next wrap, never in the middle of a pass.

The counter is one bit wider than the RAM address, and only its low bits address the RAM. The data width, address width and delay-port width are parameters. The default depth is 4096 entries. An address width of 14 gives 16K entries, and a width of 11 with 9-bit data gives a 2048-cycle delay for a 9-bit stream.

Top module: `dly_line`

## Requirements
- R1: In steady state, with a delay D in the range 2 to 2**ADDR_W+1, `dout` after clock edge e equals the `din` sampled at edge e-D. Steady state means at least D+2 edges after reset, or after the new length took effect.
- R2: A `delay_len` below 2 behaves as 2. A `delay_len` above 2**ADDR_W+1 behaves as 2**ADDR_W+1.
- R3: A change of `delay_len` is used only at the next wrap of the address counter. Outputs up to one edge after that wrap still follow the old delay.
- R4: While `rst_n` is low, `dout` is zero and the counter is zero. The first edge with `rst_n` high is a wrap. Wraps then fall on edges 1 + j*(D-1).
- R5: Between wraps the counter decrements by one each edge. At a wrap it loads the clamped delay minus 2.
- R6: The RAM is read-before-write on its single port. A read returns the value the location held before that edge's write.
- R7: With DATA_W=9 and ADDR_W=11, every bit of the 9-bit stream obeys R1 for delays up to 2049. Requests above 2049 are clamped to 2049.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the counter and the output register (RAM contents are not reset) |
| din | input | DATA_W | Sample written into the line each clock |
| delay_len | input | DLY_W | Requested delay in clock cycles; read only at a counter wrap |
| dout | output | DATA_W | Delayed sample |

## Verification
The hardest situation to bring about is a length change in the middle of a pass. The wrap edge is hidden inside the counter, so the bench cannot see when it happens. The bench works out the wrap edges from the reset phase rule in R4. It changes the delay well inside a pass, then checks that the outputs up to one edge after the next wrap still follow the old length. After one full pass at the new length, it checks that the output follows the new length.

// File: rtl/dly_pkg.sv
package dly_pkg;

  // Clamp a requested delay into the supported range [2, max_d].
  function automatic int unsigned clamp_delay(input int unsigned req,
                                              input int unsigned max_d);
    if (req < 2) return 2;
    if (req > max_d) return max_d;
    return req;
  endfunction

  // Counter start value: one cycle for the registered RAM read,
  // one for the output register.
  function automatic int unsigned reload_count(input int unsigned d);
    return d - 2;
  endfunction

endpackage

// File: rtl/dly_addr_ctr.sv
module dly_addr_ctr #(
  parameter int ADDR_W = 12,
  parameter int DLY_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  req_delay,
  output logic [ADDR_W-1:0] addr
);
  localparam int          CW        = ADDR_W + 1;
  localparam int unsigned MAX_DELAY = (1 << ADDR_W) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;
  logic [CW-1:0] load_val;
  logic          wrap;

  assign cnt_dec  = cnt_q - 1'b1;
  assign wrap     = cnt_dec[CW-1];
  assign load_val = CW'(dly_pkg::reload_count(
                      dly_pkg::clamp_delay(32'(req_delay), MAX_DELAY)));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wrap) cnt_q <= load_val;
    else cnt_q <= cnt_dec;
  end

  assign addr = cnt_q[ADDR_W-1:0];

  // R3: without a wrap the counter only steps down; delay_len is not used
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> cnt_q == $past(cnt_q) - 1'b1);

  // R5: at a wrap the counter takes the clamped delay minus two
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == $past(load_val));

  // R5: the stored count is never negative
  assert_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_q[CW-1]);
endmodule

// File: rtl/dly_ram.sv
module dly_ram #(
  parameter int DATA_W = 1,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    rd_data   <= mem[addr];
    mem[addr] <= wr_data;
  end

  logic [1:0] prime_q = 2'b00;
  always_ff @(posedge clk) prime_q <= {prime_q[0], 1'b1};

  // R6: same address on two edges: the second read sees the first write
  assert_read_before_write_R6: assert property (@(posedge clk)
    disable iff (!prime_q[1])
    ($past(addr) == $past(addr, 2)) |-> rd_data == $past(wr_data, 2));
endmodule

// File: rtl/dly_line.sv
module dly_line #(
  parameter int DATA_W = 1,
  parameter int ADDR_W = 12,
  parameter int DLY_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DLY_W-1:0]  delay_len,
  output logic [DATA_W-1:0] dout
);
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_q;

  dly_addr_ctr #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_delay (delay_len),
    .addr      (ram_addr)
  );

  dly_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .addr    (ram_addr),
    .wr_data (din),
    .rd_data (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else dout <= ram_q;
  end

  // R1: the output stage adds exactly one cycle to the RAM read
  assert_out_follows_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> dout == $past(ram_q));

  // R4: the output is cleared while reset is held
  assert_reset_clear_R4: assert property (@(posedge clk)
    !rst_n |=> (dout == '0) || rst_n);
endmodule

// File: tb/dly_line_tb.sv
`timescale 1ns/1ps
module dly_line_tb;
  localparam int HIST = 4200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic [12:0] delay_len = 13'd2;
  logic        dout;
  logic [8:0]  din_w = '0;
  logic [11:0] delay_w = 12'd2;
  logic [8:0]  dout_w;

  int  ecnt = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic       hist   [HIST];
  logic [8:0] hist_w [HIST];

  always #4 clk = ~clk;

  dly_line u_dut (.clk(clk), .rst_n(rst_n), .din(din),
                  .delay_len(delay_len), .dout(dout));

  dly_line #(.DATA_W(9), .ADDR_W(11)) u_dut_w (.clk(clk), .rst_n(rst_n),
                  .din(din_w), .delay_len(delay_w), .dout(dout_w));

  always @(posedge clk) begin
    if (!rst_n) ecnt <= 0;
    else begin
      hist[(ecnt + 1) % HIST]   <= din;
      hist_w[(ecnt + 1) % HIST] <= din_w;
      ecnt <= ecnt + 1;
    end
  end

  task automatic do_reset(input int d, input int dw);
    @(negedge clk);
    rst_n = 1'b0;
    delay_len = 13'(d);
    delay_w = 12'(dw);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Run until edge e_end; check narrow lane against delay d from edge f,
  // wide lane against dw from edge wf (d or dw of 0 disables a lane).
  task automatic run_to(input int e_end, input int d, input int f,
                        input int dw, input int wf, input string tag);
    while (ecnt < e_end) begin
      @(posedge clk);
      @(negedge clk);
      if (d > 0 && ecnt >= f) begin
        n_tests++;
        if (dout !== hist[(ecnt - d) % HIST]) begin
          n_fail++;
          $display("FAIL %s edge %0d: dout=%0b expected %0b (delay %0d)",
                   tag, ecnt, dout, hist[(ecnt - d) % HIST], d);
        end
      end
      if (dw > 0 && ecnt >= wf) begin
        n_tests++;
        if (dout_w !== hist_w[(ecnt - dw) % HIST]) begin
          n_fail++;
          $display("FAIL %s wide edge %0d: dout_w=%0h expected %0h (delay %0d)",
                   tag, ecnt, dout_w, hist_w[(ecnt - dw) % HIST], dw);
        end
      end
      din = 1'($urandom);
      din_w = 9'($urandom);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b1;
    din_w = 9'h1ff;
    repeat (3) @(negedge clk);
    n_tests++;
    if (dout !== 1'b0 || dout_w !== 9'h0) begin
      n_fail++;
      $display("FAIL R4 reset: dout=%0b dout_w=%0h expected 0 0", dout, dout_w);
    end
  endtask

  task automatic t_fixed(input int d, input int dw, input int n, input string tag);
    int span;
    do_reset(d, dw);
    span = (d > dw ? d : dw) + 2 + n;
    run_to(span, d, d + 2, dw, dw + 2, tag);
  endtask

  // R2: out-of-range requests, expected delays given separately
  task automatic t_clamp(input int req, input int d_exp, input int reqw,
                         input int dw_exp, input string tag);
    int span;
    do_reset(req, reqw);
    span = (d_exp > dw_exp ? d_exp : dw_exp) + 2 + 200;
    run_to(span, d_exp, d_exp + 2, dw_exp, dw_exp + 2, tag);
  endtask

  // R3/R5: change length from 40 to 25 in the middle of a pass.
  // Wraps at 1 + j*39: edge 118, then 157. Old delay valid through 158,
  // new delay valid from 157 + 25 + 1 = 183.
  task automatic t_change();
    do_reset(40, 7);
    run_to(128, 40, 42, 7, 9, "R1 pre-change");
    delay_len = 13'd25;
    run_to(158, 40, 129, 7, 9, "R3 old length until wrap");
    run_to(182, 0, 0, 7, 9, "R3 transition");
    run_to(400, 25, 183, 7, 9, "R5 new length after wrap");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();                                      // R4
    t_fixed(5, 7, 200, "R1 d=5");
    t_fixed(2, 2, 200, "R1 d=2 min");
    t_fixed(3, 9, 200, "R1 d=3");
    t_fixed(3454, 2048, 300, "R1/R7 d=3454 w=2048");
    t_fixed(4097, 2049, 200, "R1/R7 d=max");
    t_clamp(0, 2, 0, 2, "R2 req=0");
    t_clamp(1, 2, 1, 2, "R2 req=1");
    t_clamp(8191, 4097, 4095, 2049, "R2/R7 req above max");
    t_change();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule